// File: doc/BRIEF.md
# Field Memory Power-Up Initialization Sequencer

This block sits on the host side of a serial field memory and brings the memory's write and read address pointers into a known state after power-up. When a start request arrives, it first waits out a stabilization interval. That interval is a cycle count that stands in for the supply settling time, and its default is 100 ms at 50 MHz. The block then runs the memory's write and read clocks for a block of dummy cycles and issues a write reset and a read reset. The two ports are always handled in the same cycles.

A mode input is sampled at the accepted start. It selects either the normal ordering (dummy cycles, then reset) or a recovery ordering for a start made while the supply was not yet settled (reset, dummy cycles, reset). The outputs are per-port clock enables, which gate the memory clocks, and per-port reset strobes. Each reset strobe is high in a cycle whose clock edge the memory must see, so the clock enable is also high during every reset cycle. A done flag reports completion and stays high until the next start.

Top module: `field_init_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, and from then on until a start is accepted, all clock enables, reset strobes and `done` are 0.
- R2: A start seen at a clock edge while idle or done is accepted. For the next `STAB_CYCLES` cycles, counted from that edge, every output is 0.
- R3: In normal mode (`recover`=0 at the accepted start), the wait is followed by exactly `DUMMY_CYCLES` cycles with both clock enables 1 and both resets 0. Then comes one cycle with both resets 1 and both clock enables 1.
- R4: The write and read port outputs are equal in every cycle: clock enables match and reset strobes match.
- R5: In recovery mode (`recover`=1 at the accepted start), the wait is followed by one reset cycle (resets 1, enables 1). Then come exactly `DUMMY_CYCLES` cycles with enables 1 and resets 0, then a second reset cycle.
- R6: Each reset strobe is high for a single cycle, and is low for at least two cycles before every pulse (counted from `rst_n` release) and at least two cycles after it.
- R7: `done` goes to 1 in the cycle after the final reset cycle, with all other outputs 0. It stays 1 until a start is accepted and is 0 from the cycle after that start edge.
- R8: A start seen while a sequence is running is ignored, and so is any change of `recover` during a run. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock; all timing is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to run the initialization sequence |
| recover | input | 1 | Mode at start: 0 normal, 1 recovery ordering |
| wr_clk_en | output | 1 | Enable for the memory's write clock |
| rd_clk_en | output | 1 | Enable for the memory's read clock |
| wr_rst | output | 1 | Write-pointer reset strobe |
| rd_rst | output | 1 | Read-pointer reset strobe |
| done | output | 1 | Initialization complete |

## Verification
Two of the block's functions can meet in one cycle. The first pair is a new start request and the done flag that the request must clear. The bench holds `start` high across a whole run, so the request is already present in the cycle where `done` first rises. The block must then restart at once, with `done` high for exactly one cycle. The second pair is a start request and an ordering change that both arrive during a running recovery sequence. The bench pulses `start` with `recover` flipped in the middle of the dummy phase. A behavioural model, counting cycles since the accepted start, judges every cycle; it expects the original recovery ordering to carry on unchanged.

// File: rtl/iseq_pkg.sv
// Package: shared state encoding for the power-up initialization sequencer.
// Assumes the state register is one-hot with one bit per phase.
package iseq_pkg;
    localparam int unsigned NUM_ST = 6;
    localparam int unsigned ST_IDLE  = 0;
    localparam int unsigned ST_WAIT  = 1;
    localparam int unsigned ST_RSTA  = 2;
    localparam int unsigned ST_DUMMY = 3;
    localparam int unsigned ST_RSTB  = 4;
    localparam int unsigned ST_DONE  = 5;

    typedef logic [NUM_ST-1:0] st_oh_t;

    localparam st_oh_t ST_IDLE_OH = st_oh_t'(1) << ST_IDLE;

    // Port control pair that both memory ports receive identically.
    typedef struct packed {
        logic clk_en;
        logic rst;
    } port_ctl_t;
endpackage

// File: rtl/iseq_cycle_counter.sv
// Module: down counter that measures a fixed span of LEN cycles.
// A load pulse starts the span. 'expired' is high in the last cycle of
// the span, which is LEN cycles after the load edge, and stays high
// while the counter is at rest. Assumes LEN >= 1.
module iseq_cycle_counter #(
    parameter int unsigned LEN = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    // Load the span length minus one, then count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(LEN - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/iseq_fsm.sv
// Module: one-hot phase controller of the initialization sequencer.
// It accepts a start only while idle or done, latches the mode at that
// start, and steps through the wait, first reset (recovery only), dummy
// and final reset phases. The phase lengths come from two external
// counters. An illegal state vector falls back to idle.
module iseq_fsm
    import iseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   recover,
    input  logic   wait_exp,
    input  logic   dummy_exp,
    output logic   wait_load,
    output logic   dummy_load,
    output st_oh_t st
);
    st_oh_t st_q;
    st_oh_t st_d;
    logic   rec_q;
    logic   accept;
    logic   wait_end;

    assign accept   = start & (st_q[ST_IDLE] | st_q[ST_DONE]);
    assign wait_end = st_q[ST_WAIT] & wait_exp;

    // Next-state equations, one per phase bit.
    always_comb begin
        st_d           = '0;
        st_d[ST_IDLE]  = st_q[ST_IDLE] & ~start;
        st_d[ST_WAIT]  = accept | (st_q[ST_WAIT] & ~wait_exp);
        st_d[ST_RSTA]  = wait_end & rec_q;
        st_d[ST_DUMMY] = (wait_end & ~rec_q) | st_q[ST_RSTA]
                       | (st_q[ST_DUMMY] & ~dummy_exp);
        st_d[ST_RSTB]  = st_q[ST_DUMMY] & dummy_exp;
        st_d[ST_DONE]  = st_q[ST_RSTB] | (st_q[ST_DONE] & ~start);
        if (!$onehot(st_q)) begin
            st_d = ST_IDLE_OH;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE_OH;
        end else begin
            st_q <= st_d;
        end
    end

    // Mode latch, written only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= 1'b0;
        end else if (accept) begin
            rec_q <= recover;
        end
    end

    assign wait_load  = accept;
    assign dummy_load = (wait_end & ~rec_q) | st_q[ST_RSTA];
    assign st         = st_q;
endmodule

// File: rtl/field_init_seq.sv
// Module: power-up initialization sequencer for a serial field memory
// (top). It drives the clock enables and reset strobes of both memory
// ports identically and reports completion.
// Assumes STAB_CYCLES >= 2 and DUMMY_CYCLES >= 2, so that each reset
// strobe has its low guard around every pulse without extra states.
module field_init_seq
    import iseq_pkg::*;
#(
    parameter int unsigned STAB_CYCLES  = 5_000_000,
    parameter int unsigned DUMMY_CYCLES = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic recover,
    output logic wr_clk_en,
    output logic rd_clk_en,
    output logic wr_rst,
    output logic rd_rst,
    output logic done
);
    localparam int unsigned NUM_PORTS = 2;

    st_oh_t    st;
    logic      wait_load;
    logic      dummy_load;
    logic      wait_exp;
    logic      dummy_exp;
    port_ctl_t ctl;
    port_ctl_t port_ctl [NUM_PORTS];

    iseq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .recover    (recover),
        .wait_exp   (wait_exp),
        .dummy_exp  (dummy_exp),
        .wait_load  (wait_load),
        .dummy_load (dummy_load),
        .st         (st)
    );

    iseq_cycle_counter #(.LEN(STAB_CYCLES)) u_wait_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wait_load),
        .expired (wait_exp)
    );

    iseq_cycle_counter #(.LEN(DUMMY_CYCLES)) u_dummy_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dummy_load),
        .expired (dummy_exp)
    );

    // Decode the phase into the shared port control; reset cycles carry a clock.
    always_comb begin
        ctl.rst    = st[ST_RSTA] | st[ST_RSTB];
        ctl.clk_en = st[ST_DUMMY] | ctl.rst;
    end

    // Fan the shared control out to each memory port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign port_ctl[p] = ctl;
    end

    assign wr_clk_en = port_ctl[0].clk_en;
    assign wr_rst    = port_ctl[0].rst;
    assign rd_clk_en = port_ctl[1].clk_en;
    assign rd_rst    = port_ctl[1].rst;
    assign done      = st[ST_DONE];
endmodule

// File: rtl/iseq_chk.sv
// Module: property checker for field_init_seq, attached by bind.
// It observes only the top-level ports.
module iseq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic wr_clk_en,
    input logic rd_clk_en,
    input logic wr_rst,
    input logic rd_rst,
    input logic done
);
    logic [1:0] low_run_q;

    // Count low cycles of the write reset strobe since reset or since the last pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_rst) begin
            low_run_q <= '0;
        end else if (low_run_q != 2'd3) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !wr_clk_en && !rd_clk_en && !wr_rst && !rd_rst));

    // R4
    ports_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clk_en == rd_clk_en) && (wr_rst == rd_rst));

    // R3
    rst_has_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rst |-> wr_clk_en);

    // R6
    rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rst |=> !wr_rst);

    // R6
    rst_gap_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_rst) |=> !wr_rst);

    // R6
    rst_gap_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rst |-> (low_run_q >= 2'd2));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_clk_en && !wr_rst));

    // R7
    done_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_rst));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

bind field_init_seq iseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wr_clk_en (wr_clk_en),
    .rd_clk_en (rd_clk_en),
    .wr_rst    (wr_rst),
    .rd_rst    (rd_rst),
    .done      (done)
);

// File: tb/field_init_seq_tb_top.sv
// Bench: behavioural cycle-count reference model, compared on every clock.
module field_init_seq_tb_top;
    localparam int STAB = 24;
    localparam int DUM  = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic recover = 1'b0;
    logic wr_clk_en, rd_clk_en, wr_rst, rd_rst, done;

    int checks = 0;
    int fails = 0;
    int ticks = 0;
    bit finished = 1'b0;

    // Reference model state.
    bit m_busy = 1'b0;
    bit m_rec = 1'b0;
    bit m_done = 1'b0;
    bit m_ignored = 1'b0;
    int m_k = 0;
    int gap = 0;

    always #10 clk = ~clk;

    field_init_seq #(.STAB_CYCLES(STAB), .DUMMY_CYCLES(DUM)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .recover(recover),
        .wr_clk_en(wr_clk_en), .rd_clk_en(rd_clk_en),
        .wr_rst(wr_rst), .rd_rst(rd_rst), .done(done)
    );

    function automatic int last_k();
        return m_rec ? STAB + DUM + 1 : STAB + DUM;
    endfunction

    // Model update: k counts cycles since the accepted start edge.
    always @(posedge clk) begin
        ticks++;
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_k = 0; m_ignored = 1'b0;
        end else if (m_busy) begin
            if (start) m_ignored = 1'b1;
            m_k++;
            if (m_k > last_k()) begin
                m_busy = 1'b0; m_done = 1'b1;
            end
        end else if (start) begin
            m_busy = 1'b1; m_k = 0; m_rec = recover;
            m_done = 1'b0; m_ignored = 1'b0;
        end
    end

    // Per-cycle comparison with the model, away from the active edge.
    always @(negedge clk) begin
        logic e_en, e_rst, e_done;
        string tag;
        if (ticks > 0 && !finished) begin
            e_en = 1'b0; e_rst = 1'b0; e_done = 1'b0;
            if (!m_busy) begin
                e_done = m_done;
                tag = m_done ? "R7" : "R1";
            end else if (m_k < STAB) begin
                tag = "R2";
            end else begin
                tag = m_rec ? "R5" : "R3";
                e_en = 1'b1;
                e_rst = (m_k == last_k()) || (m_rec && m_k == STAB);
            end
            if (m_ignored) tag = "R8";
            if (wr_clk_en != rd_clk_en || wr_rst != rd_rst) tag = "R4";
            checks++;
            if (wr_clk_en !== e_en || rd_clk_en !== e_en || wr_rst !== e_rst ||
                rd_rst !== e_rst || done !== e_done) begin
                fails++;
                $display("FAIL %s t=%0d: got en=%b/%b rst=%b/%b done=%b expected en=%b rst=%b done=%b",
                         tag, ticks, wr_clk_en, rd_clk_en, wr_rst, rd_rst, done, e_en, e_rst, e_done);
            end
            // R6 guard: at least two low cycles before each single-cycle pulse
            if (!rst_n) begin
                gap = 0;
            end else if (wr_rst === 1'b1) begin
                checks++;
                if (gap < 2) begin
                    fails++;
                    $display("FAIL R6 t=%0d: low cycles before pulse got %0d expected >=2", ticks, gap);
                end
                gap = 0;
            end else begin
                gap++;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        while (!m_done) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got no completion expected finish within 20000 cycles");
            summary();
        end
    end

    initial begin
        // R1: reset state
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        // R2, R3: normal run
        start = 1'b1; recover = 1'b0;
        cyc(1);
        start = 1'b0;
        wait_done();
        cyc(6);  // R7: done holds
        // R5 with R8: recovery run, ignored start and mode flip mid dummy phase
        start = 1'b1; recover = 1'b1;
        cyc(1);
        start = 1'b0;
        cyc(STAB + 30);
        start = 1'b1; recover = 1'b0;
        cyc(2);
        start = 1'b0;
        wait_done();
        cyc(4);
        // R7: start held high, done lasts one cycle and restarts at once
        start = 1'b1; recover = 1'b0;
        cyc(2 * (STAB + DUM + 3));
        start = 1'b0;
        wait_done();
        cyc(3);
        // R1: reset in the middle of a recovery run
        start = 1'b1; recover = 1'b1;
        cyc(1);
        start = 1'b0;
        cyc(STAB + 15);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(5);
        // R5: final recovery run to completion
        start = 1'b1; recover = 1'b1;
        cyc(1);
        start = 1'b0; recover = 1'b0;
        wait_done();
        cyc(4);
        summary();
    end
endmodule